// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches sixteen asynchronous interrupt pins. Each pin first passes through a two-flop synchronizer. A per-channel input enable then decides whether the pin takes part in detection. Detection uses one of four sense modes: low level, falling edge, rising edge or both edges. A qualifying event sets a sticky status flag for that channel. A flag drives a request only when that channel's request enable is also set. The sixteen gated requests leave the block as a registered vector, together with a registered OR of the whole vector.

Software uses a small word-wide register port. It programs the input enables, the sense modes and the request enables, and it reads the flags. A flag is cleared by writing 1 to its bit.

In low-level mode the flag keeps setting itself for as long as the synchronized pin stays low. The handler therefore has to release the pin before a clear can take effect.

Top module: `ext_irq_detect`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq_vec` and `irq_any` are zero. Register addresses: 0 = input enable (bit i = channel i), 1 = sense select (channel i in bits [2i+1:2i]), 2 = request enable (bit i = channel i), 3 = flags. `rdata` shows the register that `addr` selected at the previous rising edge.
- R2: A channel whose input-enable bit is 0 never sets its flag, whatever its pin does.
- R3: Sense code 00 (low level) sets the flag while the synchronized pin is low.
- R4: Sense code 01 (falling edge) sets the flag on a high-to-low transition only, not on a rise.
- R5: Sense code 10 (rising edge) sets the flag on a low-to-high transition only, not on a fall.
- R6: Sense code 11 (both edges) sets the flag on either transition.
- R7: A set flag stays set until a write to address 3 carries a 1 in its bit. Writing 0 to a bit leaves that flag unchanged.
- R8: When a set event and a clear fall in the same cycle, the set wins. In low-level mode a pin that is still low keeps the flag set through a clear. Once the pin is high, a clear takes effect.
- R9: `irq_vec[i]` is 1 exactly when flag i and request enable i were both set one cycle earlier. A flag with its request enable at 0 produces no request.
- R10: `irq_any` is the OR of the gated requests, with the same timing as `irq_vec`.
- R11: A pin change first sampled at rising edge k can set the flag at edge k+2 at the earliest, and can raise `irq_vec` at edge k+3 at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | N_CH | Asynchronous interrupt pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 2*N_CH | Write data |
| rdata | output | 2*N_CH | Registered read data |
| irq_vec | output | N_CH | Gated per-channel requests |
| irq_any | output | 1 | OR of all gated requests |

## Verification
The hardest situation to reach from the ports is a flag clear that lands while a low-level pin is still asserted. Set-wins only becomes visible if the clear and the live set event meet in the same cycle. The stimulus holds the pin low past the synchronizer delay and then issues the write-1-to-clear. It reads the flag back while the pin is still low, then releases the pin, waits out the synchronizer and clears again. The edge modes are also driven through transitions of both directions, with channels of different modes sharing the same moves, so that a wrong-direction detection shows up in the flag word.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] REG_INEN  = 2'd0;
  localparam logic [REG_AW-1:0] REG_SENSE = 2'd1;
  localparam logic [REG_AW-1:0] REG_REQEN = 2'd2;
  localparam logic [REG_AW-1:0] REG_FLAG  = 2'd3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N_CH   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] pin_i,
  output logic [N_CH-1:0] sync_o
);
  logic [N_CH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/irq_chan_det.sv
module irq_chan_det
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       level_i,
  input  logic       in_en_i,
  input  logic [1:0] sense_i,
  input  logic       clr_i,
  output logic       flag_o
);
  logic prev_q;
  logic fell, rose, hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= level_i;
  end

  assign fell = prev_q & ~level_i;
  assign rose = ~prev_q & level_i;

  always_comb begin
    unique case (sense_e'(sense_i))
      SENSE_LOW:  hit = ~level_i;
      SENSE_FALL: hit = fell;
      SENSE_RISE: hit = rose;
      SENSE_BOTH: hit = fell | rose;
      default:    hit = 1'b0;
    endcase
  end

  // set dominates clear
  always_ff @(posedge clk) begin
    if (rst)                  flag_o <= 1'b0;
    else if (hit && in_en_i)  flag_o <= 1'b1;
    else if (clr_i)           flag_o <= 1'b0;
  end

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    (!in_en_i && !flag_o) |=> !flag_o); // R2
  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (rst)
    (in_en_i && sense_i == 2'b00 && !level_i) |=> flag_o); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o); // R7
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import ext_irq_pkg::*;
#(
  parameter int N_CH = 16,
  localparam int DW  = 2 * N_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [N_CH-1:0]   flags_i,
  output logic [N_CH-1:0]   in_en_o,
  output logic [DW-1:0]     sense_o,
  output logic [N_CH-1:0]   req_en_o,
  output logic [N_CH-1:0]   clr_o,
  output logic [DW-1:0]     rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_en_o  <= '0;
      sense_o  <= '0;
      req_en_o <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_INEN:  in_en_o  <= wdata[N_CH-1:0];
        REG_SENSE: sense_o  <= wdata;
        REG_REQEN: req_en_o <= wdata[N_CH-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en && addr == REG_FLAG) ? wdata[N_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (addr)
        REG_INEN:  rdata_o <= DW'(in_en_o);
        REG_SENSE: rdata_o <= sense_o;
        REG_REQEN: rdata_o <= DW'(req_en_o);
        default:   rdata_o <= DW'(flags_i);
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int N_CH        = 16,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = 2 * N_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   irq_pin,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [N_CH-1:0]   irq_vec,
  output logic              irq_any
);
  logic [N_CH-1:0] pin_s, in_en, req_en, clr, flags;
  logic [DW-1:0]   sense;

  irq_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(irq_pin), .sync_o(pin_s)
  );

  irq_regs #(.N_CH(N_CH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .flags_i(flags), .in_en_o(in_en), .sense_o(sense), .req_en_o(req_en),
    .clr_o(clr), .rdata_o(rdata)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    irq_chan_det u_det (
      .clk(clk), .rst(rst), .level_i(pin_s[i]), .in_en_i(in_en[i]),
      .sense_i(sense[2*i +: 2]), .clr_i(clr[i]), .flag_o(flags[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_vec <= '0;
      irq_any <= 1'b0;
    end else begin
      irq_vec <= flags & req_en;
      irq_any <= |(flags & req_en);
    end
  end

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    ((irq_vec & ~$past(req_en)) == '0)); // R9
  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (rst)
    (irq_any == (|irq_vec))); // R10
endmodule

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;
  localparam int N = 16;
  localparam int DW = 2 * N;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, irq_any;
  logic [N-1:0] irq_pin = '1, irq_vec;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ext_irq_detect #(.N_CH(N)) uut (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_vec(irq_vec), .irq_any(irq_any)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    tick(1);
    d = rdata;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reset register", v, '0);
    end
    chk("R1 reset irq_vec", DW'(irq_vec), '0);
    chk("R1 reset irq_any", DW'(irq_any), '0);
  endtask

  task automatic t_disabled;
    logic [DW-1:0] v;
    wr(2, DW'({N{1'b1}}));
    irq_pin[3] = 1'b0;
    tick(5);
    irq_pin[3] = 1'b1;
    tick(4);
    rd(3, v);
    chk("R2 disabled input flag", v, '0);
    chk("R2 disabled input irq_any", DW'(irq_any), '0);
  endtask

  task automatic t_level;
    logic [DW-1:0] v;
    wr(0, 32'h0001);
    irq_pin[0] = 1'b0;
    tick(3);
    chk("R11 irq not before third edge", DW'(irq_vec[0]), 0);
    tick(1);
    chk("R3 low level raises irq", DW'(irq_vec[0]), 1);
    chk("R10 irq_any follows", DW'(irq_any), 1);
    wr(3, 32'h0001);
    tick(1);
    rd(3, v);
    chk("R8 clear loses while pin low", v, 32'h0001);
    irq_pin[0] = 1'b1;
    tick(3);
    rd(3, v);
    chk("R7 flag sticky after release", v, 32'h0001);
    wr(3, 32'h0001);
    tick(1);
    chk("R8 clear after release drops irq", DW'(irq_vec[0]), 0);
    rd(3, v);
    chk("R8 flag cleared after release", v, '0);
  endtask

  task automatic t_edges;
    logic [DW-1:0] v;
    wr(1, 32'h0000_00E4);
    wr(0, 32'h000E);
    irq_pin[3:1] = 3'b000;
    tick(4);
    rd(3, v);
    chk("R4 R5 R6 falling: ch1,ch3 set, ch2 not", v, 32'h000A);
    wr(3, 32'h000A);
    irq_pin[3:1] = 3'b111;
    tick(4);
    rd(3, v);
    chk("R4 R5 R6 rising: ch2,ch3 set, ch1 not", v, 32'h000C);
    wr(3, '0);
    rd(3, v);
    chk("R7 write zero keeps flags", v, 32'h000C);
    wr(3, 32'h0004);
    rd(3, v);
    chk("R7 partial clear", v, 32'h0008);
    wr(3, 32'h0008);
    rd(3, v);
    chk("R7 cleared", v, '0);
  endtask

  task automatic t_gating;
    logic [DW-1:0] v;
    wr(2, '0);
    wr(0, 32'h8000);
    irq_pin[15] = 1'b0;
    tick(4);
    irq_pin[15] = 1'b1;
    tick(3);
    rd(3, v);
    chk("R9 flag set with request off", v, 32'h8000);
    chk("R9 no request while disabled", DW'(irq_vec), '0);
    chk("R10 irq_any low while disabled", DW'(irq_any), '0);
    wr(2, 32'h8000);
    tick(1);
    chk("R9 request after enable", DW'(irq_vec), 32'h8000);
    chk("R10 irq_any high", DW'(irq_any), 1);
    wr(3, 32'h8000);
    tick(1);
    chk("R10 irq_any drops after clear", DW'(irq_any), 0);
    rd(2, v);
    chk("R1 request enable readback", v, 32'h8000);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_disabled();
    t_level();
    t_edges();
    t_gating();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule